// File: doc/BRIEF.md
# SPI Serial Memory Command Front-End

This block is the slave-side command engine of a byte-addressed serial nonvolatile memory. The serial clock, active-low select, serial input and active-low pause pins are brought into a fast system clock and their edges are found there. Each select-low period carries an 8-bit command, then (for array access) a 16-bit address, then data bytes. All bits are most significant first.

Decoded commands, write addresses and write bytes go out as single-cycle pulses to the protection and page-buffer logic. Array read data is fetched from a memory port with a one-cycle read latency. The block drives the serial output together with an output-enable that the pad uses for tri-state control. The internal-write busy flag comes in from outside. While it is set, only the status read is accepted.

Top module: `spi_mem_frontend`

## Requirements
- R1: After reset the output enable is low and no command, write or end pulse is issued.
- R2: Command 0x06 issues one `cmd_wren_o` pulse and command 0x04 issues one `cmd_wrdi_o` pulse. Any bits that follow in the same select period are ignored.
- R3: Command 0x05 drives `status_i` out MSB first. The byte repeats for as long as the clock runs, and this works whether or not `busy_i` is set.
- R4: Command 0x03 takes a 16-bit address, keeps only its low ADDR_W bits, and returns the memory byte at that address MSB first. The first data bit appears after the clock fall that follows the last address bit.
- R5: A read returns consecutive bytes while the clock runs. The address increments after each byte and wraps from 2^ADDR_W-1 to 0.
- R6: Command 0x02 takes a 16-bit address. Each following data byte gives one `wr_byte_o` pulse carrying the byte and its address, and the address increments with the same wrap as R5.
- R7: Command 0x01 reports exactly one byte on `wr_data_o` with a `wrsr_o` pulse. Later bytes in the same select period are ignored.
- R8: While `busy_i` is high at decode time, every command other than 0x05 produces no pulse and leaves the output disabled.
- R9: Any other command byte produces no pulse, and the output stays disabled until select falls again.
- R10: Pause taken low while the clock is low disables the output, and data-input transitions are ignored during the pause. Releasing it while the clock is low resumes the transfer exactly where it stopped.
- R11: The output is disabled whenever select is high, and each rise of select issues one `cs_rise_o` pulse.
- R12: Clock idle-high operation (mode 3) gives the same results as idle-low operation (mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock pin (asynchronous) |
| cs_n_i | input | 1 | Select pin, active low |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Pause pin, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the serial data out pad |
| busy_i | input | 1 | Internal write cycle in progress |
| status_i | input | 8 | Status byte returned by command 0x05 |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_rd_o |
| cmd_wren_o | output | 1 | Write-enable command pulse |
| cmd_wrdi_o | output | 1 | Write-disable command pulse |
| wrsr_o | output | 1 | Status-write byte pulse |
| wr_byte_o | output | 1 | Array write byte pulse |
| wr_addr_o | output | ADDR_W | Address of the array write byte |
| wr_data_o | output | 8 | Array write byte or status-write byte |
| cs_rise_o | output | 1 | Select-rise pulse (ends a sequence) |

## Verification
The bench builds the block with ADDR_W = 4, so the array has only 16 bytes. With that size a read can start at every address, and the wrap from the top address to zero shows up within three bytes, while the address bits above bit 3 are filled with garbage to confirm they are dropped. The small width also leaves room to send all 256 command codes, each with a follow-up byte, to show that only the six defined codes have any effect. Pause, busy filtering and mode 3 are exercised on top of the same model.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OPCODE, PH_ADDR_HI, PH_ADDR_LO, PH_DATA, PH_IGNORE
  } phase_t;

  typedef enum logic [1:0] {K_READ, K_WRITE, K_RDSR, K_WRSR} kind_t;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= RST;
      q      <= RST;
      q_prev <= RST;
    end else begin
      meta   <= d;
      q      <= meta;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/spi_fe_txshift.sv
module spi_fe_txshift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       shift,
  output logic       so,
  output logic       near_end
);
  logic [7:0] nxt, sr;
  logic [2:0] ocnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt <= '0; sr <= '0; ocnt <= '0; so <= 1'b0; near_end <= 1'b0;
    end else begin
      near_end <= 1'b0;
      if (restart) ocnt <= '0;
      if (load) nxt <= load_val;
      if (shift) begin
        if (ocnt == 3'd0) begin
          so <= nxt[7];
          sr <= {nxt[6:0], 1'b0};
        end else begin
          so <= sr[7];
          sr <= {sr[6:0], 1'b0};
        end
        ocnt     <= ocnt + 3'd1;
        near_end <= (ocnt == 3'd6);
      end
    end
  end
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              si_i,
  input  logic              hold_n_i,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic              busy_i,
  input  logic [7:0]        status_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              cmd_wren_o,
  output logic              cmd_wrdi_o,
  output logic              wrsr_o,
  output logic              wr_byte_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              cs_rise_o
);
  localparam int NPIN = 4;
  localparam logic [NPIN-1:0] PIN_RST = 4'b0110; // sck, cs_n, hold_n, si

  function automatic logic [ADDR_W-1:0] trim_addr(input logic [15:0] a);
    return a[ADDR_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic [NPIN-1:0] pin_s, pin_p;
  spi_fe_sync #(.W(NPIN), .RST(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_i, cs_n_i, hold_n_i, si_i}),
    .q(pin_s), .q_prev(pin_p)
  );

  wire sck_s    = pin_s[3];
  wire cs_n_s   = pin_s[2];
  wire hold_n_s = pin_s[1];
  wire si_s     = pin_s[0];

  // named events for the checker
  wire cs_act  = !cs_n_s;
  wire cs_fall = pin_p[2] & ~cs_n_s;
  wire cs_rise = ~pin_p[2] & cs_n_s;
  logic held;
  wire rise_ev = cs_act & ~held & sck_s & ~pin_p[3];
  wire fall_ev = cs_act & ~held & ~sck_s & pin_p[3];
  wire sck_lvl = sck_s;

  phase_t phase;
  kind_t  kind;
  logic [2:0] bcnt;
  logic [7:0] sh, addr_hi;
  logic [ADDR_W-1:0] addr_q;
  logic out_en, mem_rd_q, rd_pend, stat_ld, tx_rst;
  logic wren_q, wrdi_q, wrsr_q, wrb_q, end_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [7:0] wr_data_q;
  logic tx_so, tx_near;

  wire [7:0] byte_in   = {sh[6:0], si_s};
  wire       byte_done = rise_ev && (bcnt == 3'd7);
  wire       in_ignore = (phase == PH_IGNORE);
  wire       shifting  = (phase == PH_DATA) && (kind == K_READ || kind == K_RDSR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0; phase <= PH_IDLE; kind <= K_READ; bcnt <= '0;
      sh <= '0; addr_hi <= '0; addr_q <= '0; out_en <= 1'b0;
      mem_rd_q <= 1'b0; rd_pend <= 1'b0; stat_ld <= 1'b0; tx_rst <= 1'b0;
      wren_q <= 1'b0; wrdi_q <= 1'b0; wrsr_q <= 1'b0; wrb_q <= 1'b0; end_q <= 1'b0;
      wr_addr_q <= '0; wr_data_q <= '0;
    end else begin
      wren_q <= 1'b0; wrdi_q <= 1'b0; wrsr_q <= 1'b0; wrb_q <= 1'b0; end_q <= 1'b0;
      mem_rd_q <= 1'b0; stat_ld <= 1'b0; tx_rst <= 1'b0;
      rd_pend <= mem_rd_q;
      if (!sck_s) held <= !hold_n_s;
      if (cs_fall) begin
        phase <= PH_OPCODE; bcnt <= '0; out_en <= 1'b0; tx_rst <= 1'b1;
      end else if (cs_rise) begin
        phase <= PH_IDLE; out_en <= 1'b0; end_q <= 1'b1;
      end else if (rise_ev && phase != PH_IDLE && phase != PH_IGNORE) begin
        sh   <= byte_in;
        bcnt <= bcnt + 3'd1;
        if (byte_done) begin
          case (phase)
            PH_OPCODE: begin
              if (busy_i && byte_in != OP_RDSR) phase <= PH_IGNORE;
              else begin
                case (byte_in)
                  OP_WREN:  begin wren_q <= 1'b1; phase <= PH_IGNORE; end
                  OP_WRDI:  begin wrdi_q <= 1'b1; phase <= PH_IGNORE; end
                  OP_RDSR:  begin kind <= K_RDSR; phase <= PH_DATA; out_en <= 1'b1;
                                  stat_ld <= 1'b1; tx_rst <= 1'b1; end
                  OP_WRSR:  begin kind <= K_WRSR;  phase <= PH_DATA; end
                  OP_READ:  begin kind <= K_READ;  phase <= PH_ADDR_HI; end
                  OP_WRITE: begin kind <= K_WRITE; phase <= PH_ADDR_HI; end
                  default:  phase <= PH_IGNORE;
                endcase
              end
            end
            PH_ADDR_HI: begin addr_hi <= byte_in; phase <= PH_ADDR_LO; end
            PH_ADDR_LO: begin
              addr_q <= trim_addr({addr_hi, byte_in});
              phase  <= PH_DATA;
              if (kind == K_READ) begin
                out_en <= 1'b1; mem_rd_q <= 1'b1; tx_rst <= 1'b1;
              end
            end
            PH_DATA: begin
              if (kind == K_WRITE) begin
                wrb_q <= 1'b1; wr_addr_q <= addr_q; wr_data_q <= byte_in;
                addr_q <= step_addr(addr_q);
              end else if (kind == K_WRSR) begin
                wrsr_q <= 1'b1; wr_data_q <= byte_in; phase <= PH_IGNORE;
              end
            end
            default: ;
          endcase
        end
      end
      if (tx_near && shifting) begin
        if (kind == K_READ) begin
          addr_q <= step_addr(addr_q); mem_rd_q <= 1'b1;
        end else begin
          stat_ld <= 1'b1;
        end
      end
    end
  end

  spi_fe_txshift u_tx (
    .clk(clk), .rst_n(rst_n),
    .restart(tx_rst),
    .load(rd_pend | stat_ld),
    .load_val(rd_pend ? mem_rdata_i : status_i),
    .shift(fall_ev & out_en & shifting),
    .so(tx_so), .near_end(tx_near)
  );

  assign so_o       = tx_so;
  assign so_oe_o    = out_en & cs_act & ~held;
  assign mem_rd_o   = mem_rd_q;
  assign mem_addr_o = addr_q;
  assign cmd_wren_o = wren_q;
  assign cmd_wrdi_o = wrdi_q;
  assign wrsr_o     = wrsr_q;
  assign wr_byte_o  = wrb_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign cs_rise_o  = end_q;
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_act,
  input logic held,
  input logic sck_lvl,
  input logic in_ignore,
  input logic so_oe_o,
  input logic busy_i,
  input logic cmd_wren_o,
  input logic cmd_wrdi_o,
  input logic wrsr_o,
  input logic wr_byte_o
);
  a_r11_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !so_oe_o);
  a_r10_oe_off_paused: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !so_oe_o);
  a_r10_pause_moves_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    (held != $past(held)) |-> !$past(sck_lvl));
  a_r9_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
    in_ignore |-> !so_oe_o);
  a_r2_one_pulse_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wren_o, cmd_wrdi_o, wrsr_o, wr_byte_o}));
  a_r8_busy_blocks_wren: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wren_o || cmd_wrdi_o) |-> !$past(busy_i));
  a_r6_write_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte_o |=> !wr_byte_o);
endmodule

bind spi_mem_frontend spi_fe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .held(held), .sck_lvl(sck_lvl),
  .in_ignore(in_ignore), .so_oe_o(so_oe_o), .busy_i(busy_i),
  .cmd_wren_o(cmd_wren_o), .cmd_wrdi_o(cmd_wrdi_o), .wrsr_o(wrsr_o),
  .wr_byte_o(wr_byte_o)
);

// File: tb/spi_mem_frontend_tb.sv
module spi_mem_frontend_tb;
  localparam int AW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic [7:0] status = 8'hA5;
  logic so_o, so_oe_o, mem_rd_o, cmd_wren_o, cmd_wrdi_o, wrsr_o, wr_byte_o, cs_rise_o;
  logic [AW-1:0] mem_addr_o, wr_addr_o;
  logic [7:0] mem_rdata, wr_data_o;
  int n_chk = 0, n_err = 0;
  int n_wren = 0, n_wrdi = 0, n_wrsr = 0, n_wr = 0, n_csr = 0;
  logic [7:0] last_sr;
  logic [AW-1:0] wlog_a [0:31];
  logic [7:0] wlog_d [0:31];
  bit mode3 = 1'b0;

  always #5 clk = ~clk;

  spi_mem_frontend #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si), .hold_n_i(hold_n),
    .so_o(so_o), .so_oe_o(so_oe_o), .busy_i(busy), .status_i(status),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata),
    .cmd_wren_o(cmd_wren_o), .cmd_wrdi_o(cmd_wrdi_o), .wrsr_o(wrsr_o),
    .wr_byte_o(wr_byte_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .cs_rise_o(cs_rise_o)
  );

  function automatic logic [7:0] mfn(input logic [AW-1:0] a);
    return 8'({4'b0, a} * 8'd29 + 8'h5A);
  endfunction

  always @(posedge clk) mem_rdata <= mfn(mem_addr_o);

  always @(posedge clk) if (rst_n) begin
    if (cmd_wren_o) n_wren++;
    if (cmd_wrdi_o) n_wrdi++;
    if (wrsr_o) begin n_wrsr++; last_sr = wr_data_o; end
    if (wr_byte_o) begin wlog_a[n_wr % 32] = wr_addr_o; wlog_d[n_wr % 32] = wr_data_o; n_wr++; end
    if (cs_rise_o) n_csr++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_start();
    cs_n = 1'b0; half();
  endtask

  task automatic cs_end();
    half(); sck = mode3; half(); cs_n = 1'b1; half(); half();
  endtask

  task automatic xbyte(input logic [7:0] tx, input int hold_at, output logic [7:0] rx,
                       output bit oe_all, output bit oe_any, output bit hz_hold);
    oe_all = 1'b1; oe_any = 1'b0; hz_hold = 1'b1; rx = '0;
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0; si = tx[7-i]; half();
      if (i == hold_at) begin
        hold_n = 1'b0; half();
        if (so_oe_o) hz_hold = 1'b0;
        si = ~si; half();
        if (so_oe_o) hz_hold = 1'b0;
        si = tx[7-i]; hold_n = 1'b1; half();
      end
      rx[7-i] = so_o; oe_all &= so_oe_o; oe_any |= so_oe_o;
      sck = 1'b1; half();
    end
  endtask

  // command, 16-bit address, then nbytes of read data checked against the model
  task automatic read_seq(input logic [15:0] a, input int nbytes, input int hold_byte, input string tag);
    logic [7:0] rx; bit oa, on, hz, hdr_oe;
    logic [AW-1:0] ea;
    hdr_oe = 1'b0; ea = a[AW-1:0];
    cs_start();
    xbyte(8'h03, -1, rx, oa, on, hz); hdr_oe |= on;
    xbyte(a[15:8], -1, rx, oa, on, hz); hdr_oe |= on;
    xbyte(a[7:0], -1, rx, oa, on, hz); hdr_oe |= on;
    check(!hdr_oe, {tag, " R4 output off during header"}, int'(hdr_oe), 0);
    for (int k = 0; k < nbytes; k++) begin
      xbyte(8'h00, (k == hold_byte) ? 3 : -1, rx, oa, on, hz);
      check(rx == mfn(ea) && oa, {tag, " R4 R5 read byte"}, int'(rx), int'(mfn(ea)));
      if (k == hold_byte) check(hz, {tag, " R10 output off while paused"}, int'(hz), 1);
      ea = ea + 1'b1;
    end
    cs_end();
    check(!so_oe_o, {tag, " R11 output off after select rise"}, int'(so_oe_o), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] rx; bit oa, on, hz;
    int b0, b1, b2, b3, b4;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1
    check(!so_oe_o, "R1 output enable after reset", int'(so_oe_o), 0);
    check(n_wren + n_wrdi + n_wrsr + n_wr + n_csr == 0, "R1 no pulses after reset",
          n_wren + n_wrdi + n_wrsr + n_wr + n_csr, 0);

    // R2: WREN with trailing byte, then WRDI
    b0 = n_wren; b1 = n_wrdi; b4 = n_csr;
    cs_start(); xbyte(8'h06, -1, rx, oa, on, hz); xbyte(8'h04, -1, rx, oa, on, hz); cs_end();
    check(n_wren - b0 == 1 && n_wrdi == b1, "R2 write enable pulse", n_wren - b0, 1);
    check(n_csr - b4 == 1, "R11 select rise pulse", n_csr - b4, 1);
    cs_start(); xbyte(8'h04, -1, rx, oa, on, hz); cs_end();
    check(n_wrdi - b1 == 1, "R2 write disable pulse", n_wrdi - b1, 1);

    // R3: status read, idle and busy
    for (int bz = 0; bz < 2; bz++) begin
      busy = bz[0]; status = bz[0] ? 8'h3C : 8'hA5;
      cs_start(); xbyte(8'h05, -1, rx, oa, on, hz);
      for (int k = 0; k < 2; k++) begin
        xbyte(8'h00, -1, rx, oa, on, hz);
        check(rx == status && oa, "R3 status byte", int'(rx), int'(status));
      end
      cs_end();
    end

    // R8: busy filters everything but status read
    busy = 1'b1;
    b0 = n_wren; b1 = n_wrdi; b2 = n_wrsr; b3 = n_wr;
    cs_start(); xbyte(8'h06, -1, rx, oa, on, hz); cs_end();
    cs_start(); xbyte(8'h04, -1, rx, oa, on, hz); cs_end();
    cs_start(); xbyte(8'h01, -1, rx, oa, on, hz); xbyte(8'h8C, -1, rx, oa, on, hz); cs_end();
    cs_start(); xbyte(8'h02, -1, rx, oa, on, hz); xbyte(8'h00, -1, rx, oa, on, hz);
    xbyte(8'h01, -1, rx, oa, on, hz); xbyte(8'h77, -1, rx, oa, on, hz); cs_end();
    check(n_wren == b0 && n_wrdi == b1 && n_wrsr == b2 && n_wr == b3, "R8 busy pulses",
          (n_wren - b0) + (n_wrdi - b1) + (n_wrsr - b2) + (n_wr - b3), 0);
    cs_start(); xbyte(8'h03, -1, rx, oa, on, hz); xbyte(8'h00, -1, rx, oa, on, hz);
    xbyte(8'h02, -1, rx, oa, on, hz); xbyte(8'h00, -1, rx, oa, on, hz); cs_end();
    check(!on, "R8 busy read output off", int'(on), 0);
    busy = 1'b0;

    // R4 R5: read from every start address, high bits junk, wrap
    for (int s = 0; s < 16; s++) read_seq(16'hA5A0 | 16'(s), 3, -1, "sweep");

    // R6: page of writes across the wrap
    b3 = n_wr;
    cs_start(); xbyte(8'h02, -1, rx, oa, on, hz); xbyte(8'hFF, -1, rx, oa, on, hz);
    xbyte(8'h0E, -1, rx, oa, on, hz);
    xbyte(8'h11, -1, rx, oa, on, hz); xbyte(8'h22, -1, rx, oa, on, hz);
    xbyte(8'h33, -1, rx, oa, on, hz); cs_end();
    check(n_wr - b3 == 3, "R6 write byte count", n_wr - b3, 3);
    for (int k = 0; k < 3; k++) begin
      logic [AW-1:0] ea; logic [7:0] ed;
      ea = AW'(14 + k); ed = 8'(8'h11 * (k + 1));
      check(wlog_a[(b3 + k) % 32] == ea && wlog_d[(b3 + k) % 32] == ed, "R6 write addr/data",
            int'({wlog_a[(b3 + k) % 32], wlog_d[(b3 + k) % 32]}), int'({ea, ed}));
    end

    // R7: single status write byte
    b2 = n_wrsr; b3 = n_wr;
    cs_start(); xbyte(8'h01, -1, rx, oa, on, hz); xbyte(8'h8C, -1, rx, oa, on, hz);
    xbyte(8'h55, -1, rx, oa, on, hz); cs_end();
    check(n_wrsr - b2 == 1 && last_sr == 8'h8C && n_wr == b3, "R7 status write",
          int'(last_sr), 8'h8C);

    // R9: every undefined command code
    for (int op = 0; op < 256; op++) begin
      if (op == 6 || op == 4 || op == 5 || op == 1 || op == 3 || op == 2) continue;
      b0 = n_wren + n_wrdi + n_wrsr + n_wr;
      cs_start(); xbyte(8'(op), -1, rx, oa, on, hz); b1 = int'(on);
      xbyte(8'h06, -1, rx, oa, on, hz); b1 |= int'(on); cs_end();
      check(n_wren + n_wrdi + n_wrsr + n_wr == b0 && b1 == 0, "R9 undefined command silent",
            op, 0);
    end
    read_seq(16'h0007, 1, -1, "after-undefined R9");

    // R10: pause inside a read and inside a write
    read_seq(16'h0009, 2, 1, "pause-read");
    b3 = n_wr;
    cs_start(); xbyte(8'h02, -1, rx, oa, on, hz); xbyte(8'h00, -1, rx, oa, on, hz);
    xbyte(8'h05, -1, rx, oa, on, hz); xbyte(8'hC6, 2, rx, oa, on, hz); cs_end();
    check(n_wr - b3 == 1 && wlog_d[b3 % 32] == 8'hC6 && wlog_a[b3 % 32] == 4'h5,
          "R10 write data kept across pause", int'(wlog_d[b3 % 32]), 8'hC6);

    // R12: clock idle high
    mode3 = 1'b1; sck = 1'b1; half();
    read_seq(16'h000E, 3, -1, "mode3 R12");
    b0 = n_wren;
    cs_start(); xbyte(8'h06, -1, rx, oa, on, hz); cs_end();
    check(n_wren - b0 == 1, "R12 mode3 write enable", n_wren - b0, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule